// File: doc/BRIEF.md
# Fractional UART Baud Rate Generator

This block produces the bit timing that a UART transmitter or receiver needs, working from a single clock. A 16-bit integer divisor sets the nominal bit length in clocks. An 8-bit modulation pattern can lengthen individual bits by one clock, so the average bit period over a character can approach a non-integer clock-to-baud ratio. Each bit is timed as two half-periods, each counted down on a reloaded counter. The end of the first half marks the mid-bit sample point.

A character begins with a one-cycle start strobe and a character length, which counts the start, data, parity and stop bits. The generator then times that number of bits back to back. For each bit it reports the index of the bit being timed, a mid-bit strobe and an end-of-bit strobe. After the last bit it raises a done flag and stays idle until the next start strobe. Serial shifting, framing and the choice of modulation values are left to the surrounding logic.

Top module: `frac_baud_gen`

## Requirements
- R1: The divisor is the 16-bit value `{div_hi, div_lo}`. Divisor values 0, 1 and 2 time exactly like a divisor of 3.
- R2: Let D be the effective divisor. For each bit, `half_tick` pulses high for one cycle floor(D/2) clocks after the bit starts.
- R3: Let m be the bit's modulation bit. Each bit lasts D + m clocks, and `bit_end` pulses high for one cycle at its end. The first bit starts at the clock edge that samples `char_start`, so the first `bit_end` is seen D + m0 cycles after that edge. Each later bit starts at the edge that raises the previous `bit_end`.
- R4: Bit number k of a character (k = 0 for the start bit) uses `mod_pat[k mod 8]`. The pattern is read LSB first and wraps after 8 bits.
- R5: The divisor and the modulation pattern are sampled only at the edge where a bit starts. A change in the middle of a bit does not alter that bit's timing.
- R6: `bit_idx` is 0 from the edge that samples `char_start`. It advances by one at each `bit_end` except the last. While `bit_end` is high, it already shows the next bit.
- R7: `char_done` rises together with the last bit's `bit_end` and then holds high, with no further strobes, until the next `char_start`. That `char_start` clears it.
- R8: `char_len` is sampled at `char_start`. A value of 0 is treated as 1, and a value above 16 is treated as 16.
- R9: After reset, `half_tick`, `bit_end`, `bit_idx` and `char_done` are all 0 and no strobes occur.
- R10: `half_tick` and `bit_end` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that drives all bit timing |
| rst | input | 1 | Synchronous active-high reset |
| div_lo | input | 8 | Low byte of the integer divisor |
| div_hi | input | 8 | High byte of the integer divisor |
| mod_pat | input | 8 | Per-bit stretch pattern, read LSB first |
| char_start | input | 1 | One-cycle strobe that begins a character |
| char_len | input | 5 | Bits per character (1 to 16) |
| half_tick | output | 1 | One-cycle pulse at the mid-bit point |
| bit_end | output | 1 | One-cycle pulse at the end of each bit |
| bit_idx | output | 4 | Index of the bit being timed |
| char_done | output | 1 | High from the last bit's end until the next start |

## Verification
The embedded assertions assume only two things about the inputs: they are synchronous to `clk`, and `char_start` is a plain strobe. Under those assumptions they check the following invariants:
- the counter never sits at zero while timing;
- the index stays inside the latched length;
- the done flag holds;
- the two strobes never coincide.

The stimulus issues `char_start` only while the generator is idle. It draws divisors mostly from the range 0 to 40, so that every character fits in the run. It adds directed cases for the clamped divisors, odd divisors, a large divisor that uses the high byte, an all-ones pattern, and lengths of 0, 1, 9, 16 and above 16. In random characters, the divisor and pattern are changed at arbitrary cycles inside bits, which exercises the sampling-at-bit-start rule.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int MIN_DIV = 3;
  typedef enum logic {PH_FIRST = 1'b0, PH_SECOND = 1'b1} fbg_phase_e;
endpackage

// File: rtl/fbg_period_calc.sv
module fbg_period_calc #(
  parameter int DIV_W = 16
) (
  input  logic [DIV_W/2-1:0] div_lo,
  input  logic [DIV_W/2-1:0] div_hi,
  input  logic               mod_bit,
  output logic [DIV_W-1:0]   half1,
  output logic [DIV_W-1:0]   half2
);
  logic [DIV_W-1:0] d_raw;
  logic [DIV_W-1:0] d_eff;

  always_comb begin
    d_raw = {div_hi, div_lo};
    // R1: small divisors are clamped so both halves last at least one clock
    d_eff = (d_raw < DIV_W'(fbg_pkg::MIN_DIV)) ? DIV_W'(fbg_pkg::MIN_DIV) : d_raw;
    half1 = d_eff >> 1;
    // odd leftover and the modulation stretch both go to the second half
    half2 = d_eff - half1 + DIV_W'(mod_bit);
  end
endmodule

// File: rtl/fbg_half_timer.sv
module fbg_half_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] half1,
  input  logic [CNT_W-1:0] half2,
  output logic             bit_expire,
  output logic             half_tick,
  output logic             bit_end
);
  import fbg_pkg::*;

  logic             active;
  fbg_phase_e       phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half2_q;
  logic             at_one;

  assign at_one     = (cnt == CNT_W'(1));
  assign bit_expire = active && (phase == PH_SECOND) && at_one;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      phase     <= PH_FIRST;
      cnt       <= '0;
      half2_q   <= '0;
      half_tick <= 1'b0;
      bit_end   <= 1'b0;
    end else begin
      half_tick <= active && (phase == PH_FIRST) && at_one;
      bit_end   <= bit_expire;
      if (load) begin
        active  <= 1'b1;
        phase   <= PH_FIRST;
        cnt     <= half1;
        half2_q <= half2;
      end else if (active) begin
        if (at_one) begin
          if (phase == PH_FIRST) begin
            phase <= PH_SECOND;
            cnt   <= half2_q;
          end else begin
            active <= 1'b0;
          end
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end

  // R2: a running half-period never holds a zero count
  a_r2_cnt_live: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt != '0));
  // R10: mid-bit and end-of-bit strobes are exclusive
  a_r10_no_coincide: assert property (@(posedge clk) disable iff (rst)
    $onehot0({half_tick, bit_end}));
  // R3: a bit is at least three clocks, so end strobes never come back to back
  a_r3_end_spacing: assert property (@(posedge clk) disable iff (rst)
    bit_end |=> !bit_end);
endmodule

// File: rtl/fbg_bit_seq.sv
module fbg_bit_seq #(
  parameter int MOD_W   = 8,
  parameter int MAX_LEN = 16,
  parameter int IDX_W   = $clog2(MAX_LEN),
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             char_start,
  input  logic             bit_expire,
  input  logic [LEN_W-1:0] char_len,
  input  logic [MOD_W-1:0] mod_pat,
  output logic             load,
  output logic             mod_bit,
  output logic [IDX_W-1:0] bit_idx,
  output logic             char_done
);
  localparam int MIX_W = $clog2(MOD_W);

  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] len_clamped;
  logic [IDX_W-1:0] next_idx;
  logic             is_last;

  always_comb begin
    // R8: clamp the requested length into 1..MAX_LEN
    if (char_len == '0)
      len_clamped = LEN_W'(1);
    else if (char_len > LEN_W'(MAX_LEN))
      len_clamped = LEN_W'(MAX_LEN);
    else
      len_clamped = char_len;
  end

  assign is_last  = ({1'b0, bit_idx} == (len_q - LEN_W'(1)));
  assign load     = char_start || (bit_expire && !is_last);
  assign next_idx = char_start ? '0 : bit_idx + IDX_W'(1);
  // R4: the modulation index wraps every MOD_W bits
  assign mod_bit  = mod_pat[next_idx[MIX_W-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx   <= '0;
      len_q     <= LEN_W'(1);
      char_done <= 1'b0;
    end else if (char_start) begin
      bit_idx   <= '0;
      len_q     <= len_clamped;
      char_done <= 1'b0;
    end else if (bit_expire) begin
      if (is_last) char_done <= 1'b1;
      else         bit_idx   <= next_idx;
    end
  end

  // R6: the index stays inside the latched character length
  a_r6_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, bit_idx} < len_q));
  // R7: done holds until a new character is requested
  a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
    (char_done && !char_start) |=> char_done);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int DIV_W   = 16,
  parameter int MOD_W   = 8,
  parameter int MAX_LEN = 16,
  localparam int BYTE_W = DIV_W / 2,
  localparam int IDX_W  = $clog2(MAX_LEN),
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] div_lo,
  input  logic [BYTE_W-1:0] div_hi,
  input  logic [MOD_W-1:0]  mod_pat,
  input  logic              char_start,
  input  logic [LEN_W-1:0]  char_len,
  output logic              half_tick,
  output logic              bit_end,
  output logic [IDX_W-1:0]  bit_idx,
  output logic              char_done
);
  logic             load;
  logic             mod_bit;
  logic             bit_expire;
  logic [DIV_W-1:0] half1;
  logic [DIV_W-1:0] half2;

  fbg_bit_seq #(.MOD_W(MOD_W), .MAX_LEN(MAX_LEN), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .char_start(char_start), .bit_expire(bit_expire),
    .char_len(char_len), .mod_pat(mod_pat), .load(load), .mod_bit(mod_bit),
    .bit_idx(bit_idx), .char_done(char_done)
  );

  fbg_period_calc #(.DIV_W(DIV_W)) u_calc (
    .div_lo(div_lo), .div_hi(div_hi), .mod_bit(mod_bit),
    .half1(half1), .half2(half2)
  );

  fbg_half_timer #(.CNT_W(DIV_W)) u_timer (
    .clk(clk), .rst(rst), .load(load), .half1(half1), .half2(half2),
    .bit_expire(bit_expire), .half_tick(half_tick), .bit_end(bit_end)
  );

  // R7: done only ever rises together with an end-of-bit strobe
  a_r7_done_on_end: assert property (@(posedge clk) disable iff (rst)
    $rose(char_done) |-> bit_end);
  // R9: no strobes while the character is finished
  a_r9_quiet_when_done: assert property (@(posedge clk) disable iff (rst)
    (char_done && $past(char_done) && !$past(char_start)) |-> !half_tick);
endmodule

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] div_lo = '0, div_hi = '0, mod_pat = '0;
  logic       char_start = 1'b0;
  logic [4:0] char_len = 5'd1;
  logic       half_tick, bit_end, char_done;
  logic [3:0] bit_idx;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  frac_baud_gen u_frac_baud_gen (
    .clk(clk), .rst(rst), .div_lo(div_lo), .div_hi(div_hi), .mod_pat(mod_pat),
    .char_start(char_start), .char_len(char_len), .half_tick(half_tick),
    .bit_end(bit_end), .bit_idx(bit_idx), .char_done(char_done)
  );

  function automatic int eff_div(int d);
    return (d < 3) ? 3 : d;
  endfunction

  function automatic int eff_len(int l);
    if (l == 0) return 1;
    if (l > 16) return 16;
    return l;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Times one character against the model. mutate: change registers mid-bit (R5).
  task automatic run_char(int d, int m, int l, bit mutate);
    int len, dd, h1, per, bs, b, t;
    @(negedge clk);
    div_lo = d[7:0]; div_hi = d[15:8]; mod_pat = m[7:0]; char_len = l[4:0];
    char_start = 1'b1;
    len = eff_len(l);
    dd  = eff_div(d);
    h1  = dd / 2;
    per = dd + ((m >> 0) & 1);
    bs = 0; b = 0; t = 0;
    @(negedge clk);
    char_start = 1'b0;
    chk(bit_idx == 0 && !char_done, "R6 idx/done after start", bit_idx, 0);
    forever begin
      bit exp_h, exp_e;
      @(negedge clk);
      t++;
      exp_h = (t == bs + h1);
      exp_e = (t == bs + per);
      chk(half_tick == exp_h, "R2 half_tick", half_tick, exp_h);
      chk(bit_end == exp_e, "R3 bit_end", bit_end, exp_e);
      if (exp_e) begin
        if (b == len - 1) begin
          chk(char_done == 1'b1, "R7 done at last end", char_done, 1);
          chk(bit_idx == b, "R6 idx at last end", bit_idx, b);
          break;
        end
        b++;
        chk(bit_idx == b, "R6 idx advance", bit_idx, b);
        chk(char_done == 1'b0, "R7 done early", char_done, 0);
        // R4, R5: next bit uses the registers present at this boundary
        dd  = eff_div({div_hi, div_lo});
        h1  = dd / 2;
        per = dd + ((mod_pat >> (b % 8)) & 1);
        bs  = t;
      end
      if (mutate && ($urandom % 4 == 0)) begin
        int nd;
        nd = $urandom % 41;
        div_lo = nd[7:0]; div_hi = 8'd0;
        mod_pat = 8'($urandom);
      end
    end
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!half_tick && !bit_end && char_done, "R7 idle after char",
          {half_tick, bit_end, char_done}, 1);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!half_tick && !bit_end && bit_idx == 0 && !char_done, "R9 reset state",
          {half_tick, bit_end, bit_idx, char_done}, 0);
    end
    run_char(0, 8'h00, 3, 1'b0);     // R1 divisor 0 -> 3
    run_char(1, 8'h05, 3, 1'b0);     // R1
    run_char(2, 8'hFF, 4, 1'b0);     // R1 with stretch
    run_char(3, 8'h00, 2, 1'b0);
    run_char(7, 8'hA5, 10, 1'b0);    // odd divisor
    run_char(10, 8'h01, 9, 1'b0);    // R4 ninth bit wraps to bit 0
    run_char(6, 8'h80, 16, 1'b0);    // R4 full length
    run_char(5, 8'h3C, 0, 1'b0);     // R8 length 0 -> 1
    run_char(4, 8'h55, 25, 1'b0);    // R8 length above 16 -> 16
    run_char(259, 8'h02, 2, 1'b0);   // R1 high byte in use
    run_char(12, 8'hFF, 1, 1'b0);
    for (int k = 0; k < 60; k++) begin
      int d, m, l;
      d = $urandom % 41;
      m = $urandom % 256;
      l = $urandom % 18;
      run_char(d, m, l, k[0]);       // R5 on odd iterations
    end
    report();
  end

  initial begin
    wait (cycles > 190000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
    report();
  end
endmodule